// File: doc/BRIEF.md
# Stepped Fade Volume Controller

This block sets the playback level of a stereo sample stream. It keeps a level counter between 0 and 120 and multiplies every incoming left/right sample by the counter value over 120. A level of 120 gives unity gain, 30 gives roughly -12 dB, and 0 gives silence. The division by 120 uses a constant reciprocal multiply and truncates toward zero.

The level never jumps. A command or a pin setting only picks a target. On each sample strobe the counter moves one step toward that target, so a full swing between silence and unity gain takes 120 samples. Changes happen only on a sample strobe, so no output word ever mixes two gains.

Commands come from one of two sources. In register mode, coded operations arrive on a command port and wait until the next strobe. In pin mode, two static pins select the target directly.

Top module: `fade_level_ctrl`

## Requirements
- R1: After reset the level is 120, the target is 120, no command is pending and `out_valid` is low.
- R2: For a strobe on `in_valid`, the outputs in the next cycle are `out_valid`=1 and each channel equal to trunc(sample × L / 120), where L is the level after that strobe's update. Truncation is toward zero. Without a strobe, `out_valid` is 0 in the next cycle.
- R3: The level changes only on a strobe. At a strobe it moves by exactly one toward the target, or stays put when it already equals the target. It never leaves 0..120.
- R4: Register op code 1 (full scale) sets the target to 120.
- R5: Register op code 3 (mute) sets the target to 0. At level 0 both outputs are 0.
- R6: Register op code 2 (attenuate) sets the target to 30 only when the level at that strobe is above 30. Otherwise it is ignored and the target keeps its value.
- R7: Register op codes 4 (increment) and 5 (decrement) change the level by one at the strobe, saturating at 120 and 0. The target then equals the new level.
- R8: A command (`cmd_valid` with `cmd_op`) waits until the next strobe, and a later command replaces an earlier one. A command presented in the same cycle as a strobe applies at that strobe. Op code 0 is no operation.
- R9: When `mode_static`=1, each strobe sets the target from the pins: 0 if `st_mute`, else 30 if `st_atten`, else 120. Register commands are discarded in this mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_static | input | 1 | 1 selects pin control, 0 selects register commands |
| st_mute | input | 1 | Pin mode: mute request (wins over `st_atten`) |
| st_atten | input | 1 | Pin mode: attenuate request |
| cmd_valid | input | 1 | Register command strobe |
| cmd_op | input | 3 | Op code: 0 none, 1 full, 2 attenuate, 3 mute, 4 increment, 5 decrement |
| in_valid | input | 1 | Sample strobe |
| in_left | input | 20 | Left sample, two's complement |
| in_right | input | 20 | Right sample, two's complement |
| out_valid | output | 1 | Scaled sample strobe |
| out_left | output | 20 | Scaled left sample |
| out_right | output | 20 | Scaled right sample |
| gain_level | output | 7 | Current level counter |

## Verification
Every result is due one clock after the strobe that causes it. This covers the scaled samples, `out_valid` and the new `gain_level`. A command held while no strobe arrives must leave the level unchanged, however many cycles pass.

The bench drives inputs on the falling edge and checks on the next falling edge, after exactly one rising edge has passed. Its reference model updates the level at the moment the strobe is driven. The scaled value it expects therefore uses the level the design holds when the check samples.

// File: rtl/fade_level_ctrl.sv
module fade_level_ctrl #(
  parameter int SAMPLE_W = 20,
  parameter int LVL_W    = 7,
  parameter int FULL_LVL = 120,
  parameter int ATT_LVL  = 30
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       mode_static,
  input  logic                       st_mute,
  input  logic                       st_atten,
  input  logic                       cmd_valid,
  input  logic [2:0]                 cmd_op,
  input  logic                       in_valid,
  input  logic signed [SAMPLE_W-1:0] in_left,
  input  logic signed [SAMPLE_W-1:0] in_right,
  output logic                       out_valid,
  output logic signed [SAMPLE_W-1:0] out_left,
  output logic signed [SAMPLE_W-1:0] out_right,
  output logic [LVL_W-1:0]           gain_level
);

  localparam logic [2:0] OP_FULL = 3'd1;
  localparam logic [2:0] OP_ATT  = 3'd2;
  localparam logic [2:0] OP_MUTE = 3'd3;
  localparam logic [2:0] OP_INC  = 3'd4;
  localparam logic [2:0] OP_DEC  = 3'd5;
  localparam logic [LVL_W-1:0] L_FULL = LVL_W'(FULL_LVL);
  localparam logic [LVL_W-1:0] L_ATT  = LVL_W'(ATT_LVL);
  localparam int MAG_W   = SAMPLE_W + LVL_W;
  localparam int SH      = MAG_W + LVL_W;
  localparam longint unsigned RECIP = ((64'd1 << SH) + 64'(FULL_LVL) - 64'd1) / 64'(FULL_LVL);
  localparam int RECIP_W = SH - $clog2(FULL_LVL) + 1;
  localparam int PROD_W  = MAG_W + RECIP_W;

  logic [LVL_W-1:0] cnt, tgt, cnt_n, tgt_n;
  logic [2:0]       pend, eff;

  function automatic logic signed [SAMPLE_W-1:0] scale(
    input logic signed [SAMPLE_W-1:0] s, input logic [LVL_W-1:0] g);
    logic signed [MAG_W:0] p;
    logic [MAG_W-1:0]      m;
    logic [PROD_W-1:0]     w;
    logic [SAMPLE_W:0]     q;
    p = (MAG_W+1)'(s) * $signed({1'b0, g});
    m = MAG_W'(p[MAG_W] ? -p : p);
    w = PROD_W'(m) * PROD_W'(RECIP);
    q = (SAMPLE_W+1)'(w >> SH);
    return p[MAG_W] ? SAMPLE_W'(-$signed(q)) : SAMPLE_W'(q);
  endfunction

  assign eff        = cmd_valid ? cmd_op : pend;
  assign gain_level = cnt;

  always_comb begin
    tgt_n = tgt;
    cnt_n = cnt;
    if (mode_static) begin
      tgt_n = st_mute ? '0 : (st_atten ? L_ATT : L_FULL);
    end else begin
      case (eff)
        OP_FULL: tgt_n = L_FULL;
        OP_ATT:  if (cnt > L_ATT) tgt_n = L_ATT;
        OP_MUTE: tgt_n = '0;
        default: ;
      endcase
    end
    if (!mode_static && eff == OP_INC) begin
      cnt_n = (cnt >= L_FULL) ? L_FULL : cnt + 1'b1;
      tgt_n = cnt_n;
    end else if (!mode_static && eff == OP_DEC) begin
      cnt_n = (cnt == '0) ? '0 : cnt - 1'b1;
      tgt_n = cnt_n;
    end else if (cnt < tgt_n) begin
      cnt_n = cnt + 1'b1;
    end else if (cnt > tgt_n) begin
      cnt_n = cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt       <= L_FULL;
      tgt       <= L_FULL;
      pend      <= '0;
      out_valid <= 1'b0;
      out_left  <= '0;
      out_right <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        cnt       <= cnt_n;
        tgt       <= tgt_n;
        pend      <= '0;
        out_left  <= scale(in_left, cnt_n);
        out_right <= scale(in_right, cnt_n);
      end else if (mode_static) begin
        pend <= '0;
      end else if (cmd_valid) begin
        pend <= cmd_op;
      end
    end
  end

  p_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= L_FULL && tgt <= L_FULL);

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(cnt));

  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (cnt == $past(cnt)) || (cnt == $past(cnt) + 1'b1) || (cnt == $past(cnt) - 1'b1));

  p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> out_valid == $past(in_valid));

  p_silent_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && cnt == '0 |-> out_left == '0 && out_right == '0);

  p_att_floor_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !mode_static && cmd_valid && cmd_op == OP_ATT && cnt <= L_ATT |=> tgt == $past(tgt));

  p_inc_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !mode_static && cmd_valid && cmd_op == OP_INC && cnt < L_FULL |=> cnt == $past(cnt) + 1'b1);

  p_pin_mute_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && mode_static && st_mute |=> tgt == '0);

endmodule

// File: tb/test_fade_level_ctrl.sv
module test_fade_level_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic mode_static = 0, st_mute = 0, st_atten = 0, cmd_valid = 0, in_valid = 0;
  logic [2:0] cmd_op = '0;
  logic signed [19:0] in_left = '0, in_right = '0;
  logic out_valid;
  logic signed [19:0] out_left, out_right;
  logic [6:0] gain_level;

  int n_chk = 0, n_fail = 0;
  int m_cnt = 120, m_tgt = 120, m_pend = 0;

  always #2 clk = ~clk;

  fade_level_ctrl i_fade_level_ctrl (
    .clk, .rst_n, .mode_static, .st_mute, .st_atten, .cmd_valid, .cmd_op,
    .in_valid, .in_left, .in_right, .out_valid, .out_left, .out_right, .gain_level);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_scale(input int s, input int g);
    return (s * g) / 120;
  endfunction

  function automatic int rnd_sample();
    return int'($urandom_range(0, 1048575)) - 524288;
  endfunction

  task automatic model_strobe(input bit with_cmd, input int op);
    int eff;
    eff = with_cmd ? op : m_pend;
    m_pend = 0;
    if (mode_static) m_tgt = st_mute ? 0 : (st_atten ? 30 : 120);
    else if (eff == 1) m_tgt = 120;
    else if (eff == 2 && m_cnt > 30) m_tgt = 30;
    else if (eff == 3) m_tgt = 0;
    if (!mode_static && eff == 4) begin
      if (m_cnt < 120) m_cnt++;
      m_tgt = m_cnt;
    end else if (!mode_static && eff == 5) begin
      if (m_cnt > 0) m_cnt--;
      m_tgt = m_cnt;
    end else if (m_cnt < m_tgt) m_cnt++;
    else if (m_cnt > m_tgt) m_cnt--;
  endtask

  task automatic sample(input int l, input int r, input bit with_cmd, input int op, input string req);
    in_left = 20'(l); in_right = 20'(r); in_valid = 1'b1;
    cmd_valid = with_cmd; cmd_op = 3'(op);
    model_strobe(with_cmd, op);
    @(negedge clk);
    in_valid = 1'b0; cmd_valid = 1'b0; cmd_op = '0;
    chk(out_valid === 1'b1, "R2 out_valid", int'(out_valid), 1);
    chk(int'(gain_level) == m_cnt, req, int'(gain_level), m_cnt);
    chk(int'(out_left) == exp_scale(l, m_cnt), "R2 left", int'(out_left), exp_scale(l, m_cnt));
    chk(int'(out_right) == exp_scale(r, m_cnt), "R2 right", int'(out_right), exp_scale(r, m_cnt));
  endtask

  task automatic command(input int op);
    cmd_valid = 1'b1; cmd_op = 3'(op);
    if (!mode_static) m_pend = op;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = '0;
    chk(out_valid === 1'b0, "R2 no strobe", int'(out_valid), 0);
    chk(int'(gain_level) == m_cnt, "R8 command waits", int'(gain_level), m_cnt);
  endtask

  task automatic set_static(input bit s);
    mode_static = s;
    @(negedge clk);
    if (s) m_pend = 0;
  endtask

  task automatic ramp(input int n, input string req);
    for (int i = 0; i < n; i++) sample(rnd_sample(), rnd_sample(), 0, 0, req);
  endtask

  initial begin
    #(4 * 200000);
    chk(1'b0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(gain_level == 7'd120, "R1 level", int'(gain_level), 120);
    chk(out_valid === 1'b0, "R1 valid", int'(out_valid), 0);

    ramp(8, "R2 unity");
    sample(524287, -524288, 0, 0, "R2 extremes");
    sample(-1, 1, 0, 0, "R2 small");

    command(3);
    repeat (4) @(negedge clk);
    chk(int'(gain_level) == 120, "R8 pending held", int'(gain_level), 120);
    ramp(120, "R5 mute ramp R3");
    chk(gain_level == 7'd0, "R5 at zero", int'(gain_level), 0);
    sample(524287, -524288, 0, 0, "R5 silent");
    repeat (5) @(negedge clk);
    chk(gain_level == 7'd0, "R3 hold idle", int'(gain_level), 0);

    sample(1000, -1000, 1, 2, "R6 atten ignored at 0");
    ramp(3, "R6 target unchanged");
    chk(gain_level == 7'd0, "R6 still muted", int'(gain_level), 0);

    command(1);
    ramp(120, "R4 full ramp R3");
    chk(gain_level == 7'd120, "R4 at full", int'(gain_level), 120);
    sample(rnd_sample(), rnd_sample(), 1, 4, "R7 inc saturates");
    sample(rnd_sample(), rnd_sample(), 1, 2, "R6 atten from full");
    ramp(92, "R6 ramp to 30");
    chk(gain_level == 7'd30, "R6 at 30", int'(gain_level), 30);
    sample(rnd_sample(), rnd_sample(), 1, 2, "R6 atten at 30 ignored");
    repeat (3) sample(rnd_sample(), rnd_sample(), 1, 4, "R7 inc");
    sample(rnd_sample(), rnd_sample(), 1, 5, "R7 dec");
    chk(gain_level == 7'd32, "R7 net level", int'(gain_level), 32);

    command(3);
    command(1);
    sample(rnd_sample(), rnd_sample(), 0, 0, "R8 latest wins");
    chk(gain_level == 7'd33, "R8 full replaced mute", int'(gain_level), 33);
    command(3);
    sample(rnd_sample(), rnd_sample(), 1, 5, "R8 same cycle command");
    sample(rnd_sample(), rnd_sample(), 1, 3, "R5 mute");
    ramp(40, "R5 ramp down");
    repeat (2) sample(rnd_sample(), rnd_sample(), 1, 5, "R7 dec saturates");
    chk(gain_level == 7'd0, "R7 floor", int'(gain_level), 0);

    st_mute = 1; st_atten = 1;
    set_static(1);
    command(1);
    sample(rnd_sample(), rnd_sample(), 1, 4, "R9 mute over atten, cmd discarded");
    chk(gain_level == 7'd0, "R9 stays muted", int'(gain_level), 0);
    st_mute = 0;
    ramp(35, "R9 pin atten ramp");
    chk(gain_level == 7'd30, "R9 pin atten", int'(gain_level), 30);
    st_atten = 0;
    ramp(10, "R9 pin full ramp");
    command(3);
    set_static(0);
    sample(rnd_sample(), rnd_sample(), 0, 0, "R9 pending discarded");
    chk(gain_level == 7'd41, "R9 no mute after switch", int'(gain_level), 41);

    for (int it = 0; it < 1500; it++) begin
      int k;
      k = int'($urandom_range(0, 19));
      if (k < 9) sample(rnd_sample(), rnd_sample(), 0, 0, "R3 random");
      else if (k < 12) command(int'($urandom_range(0, 5)));
      else if (k < 16) sample(rnd_sample(), rnd_sample(), 1, int'($urandom_range(0, 5)), "R8 random");
      else if (k < 18) begin
        @(negedge clk);
        chk(out_valid === 1'b0 && int'(gain_level) == m_cnt, "R3 random idle", int'(gain_level), m_cnt);
      end else if (k == 18) begin
        st_mute = 1'($urandom_range(0, 1)); st_atten = 1'($urandom_range(0, 1));
        @(negedge clk);
      end else set_static(1'($urandom_range(0, 1)));
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule